// File: doc/BRIEF.md
# Conditional-Move Register Datapath

This block is a small register file paired with an execute stage for partial predication. Each decoded instruction names two source registers and one destination. A signed set-less-than compare writes a 0/1 flag. Two conditional moves copy the first source into the destination only when the second source passes a zero test: one fires on zero, the other on nonzero. When the test fails, the destination keeps its old value, so software can choose between two precomputed values without a branch. A load-immediate operation seeds registers.

Instructions are presented one per clock through a valid/opcode/address interface. Results commit on the rising edge. Both source read ports are combinational and are also exposed as outputs, so the surrounding logic can inspect any register by pointing a source address at it. Operation codes (`op_i`): 0 = no-op, 1 = load immediate, 2 = set-less-than, 3 = move-if-zero, 4 = move-if-nonzero.

Top module: `cmov_datapath`

## Requirements
- R1: While `rst_ni` is low, every register is cleared to zero, and reads of every register return 0 after reset.
- R2: Op 1 (load immediate) with `valid_i` high writes `imm_i` into the destination at the next rising edge.
- R3: Op 2 (set-less-than) writes 1 into the destination when the first source is less than the second in signed two's-complement order, and 0 otherwise, including when they are equal.
- R4: Op 3 (move-if-zero) copies the first source into the destination when the second source equals zero.
- R5: Op 3 leaves the destination unchanged when the second source is nonzero.
- R6: Op 4 (move-if-nonzero) copies the first source into the destination when the second source is nonzero.
- R7: Op 4 leaves the destination unchanged when the second source equals zero.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: A read of a register in the same cycle it is being written returns the old value; the new value is visible after the edge.
- R10: The three-instruction sequence set-less-than, move-if-zero, move-if-nonzero to a common destination leaves the signed minimum of two values there, whichever is smaller, with exactly one of the two moves taking effect.
- R11: With `valid_i` low, or with op 0, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| op_i | input | 3 | Operation code (0 no-op, 1 load imm, 2 slt, 3 move-if-zero, 4 move-if-nonzero) |
| rd_addr_i | input | 5 | Destination register index |
| rs_addr_i | input | 5 | First source register index |
| rt_addr_i | input | 5 | Second source (test) register index |
| imm_i | input | 32 | Immediate value for load |
| rs_data_o | output | 32 | Combinational read of the first source |
| rt_data_o | output | 32 | Combinational read of the second source |
| wr_en_o | output | 1 | Gated write enable this cycle |
| wr_addr_o | output | 5 | Write destination index |
| wr_data_o | output | 32 | Write data |

## Verification
Every operation commits at the first rising edge after it is presented, and its effect appears on the read ports combinationally right after that edge, so each result is due one cycle after issue. The bench drives an instruction on a falling edge, lets the next rising edge commit it, clears `valid_i` on the following falling edge and samples the destination 1 ns later through a source port. The same-cycle case is sampled before the committing edge to see the old value and again one cycle later to see the new one; suppressed moves are checked by reading back the destination in that same slot.

// File: rtl/cmov_pkg.sv
package cmov_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LDI  = 3'd1,
    OP_SLT  = 3'd2,
    OP_MOVZ = 3'd3,
    OP_MOVN = 3'd4
  } op_e;
endpackage

// File: rtl/cmov_regfile.sv
module cmov_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           regs[i] <= '0;
        else if (we_i && waddr_i == AW'(i))    regs[i] <= wdata_i;
      end
    end
  end

  // reads see pre-edge contents
  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
endmodule

// File: rtl/cmov_exec.sv
module cmov_exec
  import cmov_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op_i,
  input  logic [W-1:0] rs_val_i,
  input  logic [W-1:0] rt_val_i,
  input  logic [W-1:0] imm_i,
  output logic [W-1:0] result_o,
  output logic         cond_ok_o
);
  logic rt_zero;
  logic lt;

  assign rt_zero = (rt_val_i == '0);
  assign lt      = ($signed(rs_val_i) < $signed(rt_val_i));

  always_comb begin
    result_o  = rs_val_i;
    cond_ok_o = 1'b0;
    unique case (op_i)
      OP_LDI:  begin result_o = imm_i;          cond_ok_o = 1'b1;     end
      OP_SLT:  begin result_o = W'(lt);         cond_ok_o = 1'b1;     end
      OP_MOVZ: begin result_o = rs_val_i;       cond_ok_o = rt_zero;  end
      OP_MOVN: begin result_o = rs_val_i;       cond_ok_o = !rt_zero; end
      default: begin result_o = rs_val_i;       cond_ok_o = 1'b0;     end
    endcase
  end
endmodule

// File: rtl/cmov_wr_gate.sv
module cmov_wr_gate #(
  parameter int W   = 32,
  parameter int AW  = 5
) (
  input  logic          valid_i,
  input  logic          cond_ok_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [W-1:0]  result_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [W-1:0]  wr_data_o
);
  // failed condition or r0 target: suppress, leave rd intact
  assign wr_en_o   = valid_i && cond_ok_i && (rd_addr_i != '0);
  assign wr_addr_o = rd_addr_i;
  assign wr_data_o = result_i;
endmodule

// File: rtl/cmov_datapath.sv
module cmov_datapath
  import cmov_pkg::*;
#(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [AW-1:0] rs_addr_i,
  input  logic [AW-1:0] rt_addr_i,
  input  logic [W-1:0]  imm_i,
  output logic [W-1:0]  rs_data_o,
  output logic [W-1:0]  rt_data_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [W-1:0]  wr_data_o
);
  logic [W-1:0] result;
  logic         cond_ok;

  cmov_regfile #(.NREG(NREG), .W(W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en_o),
    .waddr_i   (wr_addr_o),
    .wdata_i   (wr_data_o),
    .raddr_a_i (rs_addr_i),
    .raddr_b_i (rt_addr_i),
    .rdata_a_o (rs_data_o),
    .rdata_b_o (rt_data_o)
  );

  cmov_exec #(.W(W)) u_exec (
    .op_i      (op_e'(op_i)),
    .rs_val_i  (rs_data_o),
    .rt_val_i  (rt_data_o),
    .imm_i     (imm_i),
    .result_o  (result),
    .cond_ok_o (cond_ok)
  );

  cmov_wr_gate #(.W(W), .AW(AW)) u_gate (
    .valid_i   (valid_i),
    .cond_ok_i (cond_ok),
    .rd_addr_i (rd_addr_i),
    .result_i  (result),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );
endmodule

// File: rtl/cmov_datapath_chk.sv
module cmov_datapath_chk #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [2:0]    op_i,
  input logic [AW-1:0] rd_addr_i,
  input logic [AW-1:0] rs_addr_i,
  input logic [AW-1:0] rt_addr_i,
  input logic [W-1:0]  imm_i,
  input logic [W-1:0]  rs_data_o,
  input logic [W-1:0]  rt_data_o,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [W-1:0]  wr_data_o
);
  // R2
  ldi_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd1 && rd_addr_i != '0) |-> (wr_en_o && wr_data_o == imm_i));

  // R3
  slt_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2 && rd_addr_i != '0) |->
      (wr_en_o && wr_data_o == (($signed(rs_data_o) < $signed(rt_data_o)) ? W'(1) : W'(0))));

  // R4
  movz_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3 && rt_data_o == '0 && rd_addr_i != '0) |->
      (wr_en_o && wr_data_o == rs_data_o));

  // R5
  movz_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3 && rt_data_o != '0) |-> !wr_en_o);

  // R6
  movn_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4 && rt_data_o != '0 && rd_addr_i != '0) |->
      (wr_en_o && wr_data_o == rs_data_o));

  // R7
  movn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4 && rt_data_o == '0) |-> !wr_en_o);

  // R8
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rs_addr_i == '0 || rt_addr_i == '0) |->
      ((rs_addr_i != '0 || rs_data_o == '0) && (rt_addr_i != '0 || rt_data_o == '0))));

  // R9
  write_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_en_o) && rs_addr_i == $past(wr_addr_o)) |->
      (rs_data_o == $past(wr_data_o)));

  // R11
  idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || op_i == 3'd0) |-> !wr_en_o);
endmodule

bind cmov_datapath cmov_datapath_chk #(.NREG(NREG), .W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .rd_addr_i (rd_addr_i),
  .rs_addr_i (rs_addr_i),
  .rt_addr_i (rt_addr_i),
  .imm_i     (imm_i),
  .rs_data_o (rs_data_o),
  .rt_data_o (rt_data_o),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o)
);

// File: tb/cmov_datapath_tb_top.sv
`timescale 1ns/1ps
module cmov_datapath_tb_top;
  localparam int W  = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [2:0]    op_i = '0;
  logic [AW-1:0] rd_addr_i = '0, rs_addr_i = '0, rt_addr_i = '0;
  logic [W-1:0]  imm_i = '0;
  logic [W-1:0]  rs_data_o, rt_data_o, wr_data_o;
  logic          wr_en_o;
  logic [AW-1:0] wr_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] model [32];

  always #2.5 clk = ~clk;

  cmov_datapath dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .rd_addr_i(rd_addr_i), .rs_addr_i(rs_addr_i), .rt_addr_i(rt_addr_i),
    .imm_i(imm_i), .rs_data_o(rs_data_o), .rt_data_o(rt_data_o),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  function automatic logic [W-1:0] exp_result(input logic [2:0] op, input logic [W-1:0] rs,
                                               input logic [W-1:0] rt, input logic [W-1:0] imm,
                                               input logic [W-1:0] old);
    case (op)
      3'd1: return imm;
      3'd2: return ($signed(rs) < $signed(rt)) ? 32'd1 : 32'd0;
      3'd3: return (rt == 0) ? rs : old;
      3'd4: return (rt != 0) ? rs : old;
      default: return old;
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // issue one instruction; committed on the rising edge in between
  task automatic issue(input logic [2:0] op, input int rd, input int rs, input int rt,
                       input logic [W-1:0] imm, input logic v = 1'b1);
    @(negedge clk);
    valid_i = v; op_i = op; rd_addr_i = AW'(rd); rs_addr_i = AW'(rs);
    rt_addr_i = AW'(rt); imm_i = imm;
    @(negedge clk);
    valid_i = 1'b0; op_i = 3'd0;
    if (v && rd != 0) model[rd] = exp_result(op, model[rs], model[rt], imm, model[rd]);
  endtask

  task automatic rd_reg(input int a, output logic [W-1:0] v);
    rs_addr_i = AW'(a);
    #1;
    v = rs_data_o;
  endtask

  logic done = 1'b0;
  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'h1234));
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset state
    for (int i = 0; i < 32; i++) begin rd_reg(i, v); chk("R1 reset clear", v, 0); end

    // R2 load immediate
    issue(3'd1, 5, 0, 0, 32'hDEAD_BEEF); rd_reg(5, v); chk("R2 ldi", v, 32'hDEAD_BEEF);
    issue(3'd1, 6, 0, 0, 32'hFFFF_FFF0); rd_reg(6, v); chk("R2 ldi neg", v, 32'hFFFF_FFF0);
    issue(3'd1, 7, 0, 0, 32'd12);        rd_reg(7, v); chk("R2 ldi small", v, 32'd12);

    // R3 signed compare: -16 < 12, 12 < -16 false, equal false
    issue(3'd2, 8, 6, 7, 0); rd_reg(8, v); chk("R3 slt neg<pos", v, 1);
    issue(3'd2, 8, 7, 6, 0); rd_reg(8, v); chk("R3 slt pos<neg", v, 0);
    issue(3'd2, 8, 7, 7, 0); rd_reg(8, v); chk("R3 slt equal", v, 0);

    // R4/R5 move-if-zero
    issue(3'd1, 9, 0, 0, 32'h5555_0000);
    issue(3'd3, 9, 5, 0, 0); rd_reg(9, v); chk("R4 movz fires", v, 32'hDEAD_BEEF);
    issue(3'd3, 9, 7, 6, 0); rd_reg(9, v); chk("R5 movz holds", v, 32'hDEAD_BEEF);

    // R6/R7 move-if-nonzero
    issue(3'd4, 10, 7, 5, 0); rd_reg(10, v); chk("R6 movn fires", v, 32'd12);
    issue(3'd4, 10, 5, 0, 0); rd_reg(10, v); chk("R7 movn holds", v, 32'd12);

    // R8 r0 ignores writes
    issue(3'd1, 0, 0, 0, 32'hFFFF_FFFF); rd_reg(0, v); chk("R8 r0 zero", v, 0);
    issue(3'd4, 0, 5, 5, 0);             rd_reg(0, v); chk("R8 r0 movn", v, 0);

    // R9 same-cycle read returns old value
    @(negedge clk);
    valid_i = 1'b1; op_i = 3'd1; rd_addr_i = 5'd11; imm_i = 32'h0BAD_F00D; rs_addr_i = 5'd11;
    #1 chk("R9 old value", rs_data_o, 0);
    @(negedge clk); valid_i = 1'b0; op_i = 3'd0; model[11] = 32'h0BAD_F00D;
    rd_reg(11, v); chk("R9 new value", v, 32'h0BAD_F00D);

    // R10 min sequence: slt r1; movz r4<-b; movn r4<-a
    issue(3'd1, 2, 0, 0, 32'hFFFF_FF00); issue(3'd1, 3, 0, 0, 32'd7);
    issue(3'd2, 1, 2, 3, 0); issue(3'd3, 4, 3, 1, 0); issue(3'd4, 4, 2, 1, 0);
    rd_reg(4, v); chk("R10 min a<b", v, 32'hFFFF_FF00);
    issue(3'd1, 2, 0, 0, 32'd100);
    issue(3'd2, 1, 2, 3, 0); issue(3'd3, 4, 3, 1, 0); issue(3'd4, 4, 2, 1, 0);
    rd_reg(4, v); chk("R10 min b<a", v, 32'd7);

    // R11 valid low / nop
    issue(3'd1, 12, 0, 0, 32'h1111_2222, 1'b0); rd_reg(12, v); chk("R11 valid low", v, 0);
    issue(3'd0, 12, 5, 5, 32'h1111_2222);       rd_reg(12, v); chk("R11 nop", v, 0);

    // constrained random against the bench model
    for (int i = 0; i < 600; i++) begin
      int rd, rs, rt;
      logic [2:0] op;
      logic [W-1:0] imm;
      rd = $urandom_range(0, 15); rs = $urandom_range(0, 15); rt = $urandom_range(0, 15);
      op = 3'($urandom_range(0, 4));
      imm = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom;
      issue(op, rd, rs, rt, imm, ($urandom_range(0, 7) != 0));
      rd_reg(rd, v);
      case (op)
        3'd1: chk("R2 rand ldi", v, model[rd]);
        3'd2: chk("R3 rand slt", v, model[rd]);
        3'd3: chk("R4 R5 rand movz", v, model[rd]);
        3'd4: chk("R6 R7 rand movn", v, model[rd]);
        default: chk("R11 rand nop", v, model[rd]);
      endcase
    end
    for (int i = 0; i < 32; i++) begin rd_reg(i, v); chk("R8 R11 final sweep", v, model[i]); end

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule